// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

An iterative unsigned multiplier. It takes two W-bit operands and returns their 2W-bit product after W add-and-shift cycles, using one W-bit adder. The working state is a chain of three registers. A carry position holds the adder's carry-out. An accumulator holds the running high half of the product. A shift register holds the multiplier at the start and, at the end, the low half of the product. A separate holding register keeps the multiplicand fixed for the whole operation.

Each cycle, bit 0 of the shift register decides whether the multiplicand is added into the accumulator. The carry, accumulator and shift register then move right together by one place, with zero entering at the top. A single start pulse launches an operation. Completion is signalled with a busy level and a one-cycle done pulse. The product stays on its outputs until the next accepted start.

Top module: `shift_add_mul`

## Requirements
- R1: After reset, busy_o, done_o, prod_hi_o and prod_lo_o are all 0.
- R2: A start_i sampled high while busy_o is low is accepted. In the next cycle busy_o is 1, prod_hi_o is 0 and prod_lo_o equals the multiplier sampled with the start.
- R3: Each busy cycle performs one step. If bit 0 of prod_lo_o is 1, the multiplicand is added to prod_hi_o. Then {carry, prod_hi_o, prod_lo_o} shifts right one place, with 0 entering the carry. For W=4, multiplicand 1111 and multiplier 0101, the outputs {prod_hi_o, prod_lo_o} after steps 1 to 4 are 0111/1010, 0011/1101, 1001/0110 and 0100/1011.
- R4: busy_o stays high for exactly W cycles after the accepted start. done_o is high for exactly one cycle, the cycle in which busy_o has just fallen.
- R5: While done_o is high, {prod_hi_o, prod_lo_o} equals the unsigned product of the two operands sampled with the accepted start.
- R6: start_i is ignored while busy_o is high. The operation in flight finishes on schedule with the product of its own operands.
- R7: While busy_o is low and no start is accepted, prod_hi_o and prod_lo_o hold their value, whatever the operand inputs do.
- R8: The adder is W bits wide, and its carry-out enters the top bit of the accumulator on the shift. An all-ones multiplicand times an all-ones multiplier gives (2^W-1)^2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launches an operation when idle |
| mcand_i | input | W | Multiplicand |
| mplier_i | input | W | Multiplier |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| prod_hi_o | output | W | High half of product, or accumulator during an operation |
| prod_lo_o | output | W | Low half of product, or shift register during an operation |

## Verification
The product outputs show the accumulator and shift register directly, so a wrong add decision, a lost carry or a bad shift appears in {prod_hi_o, prod_lo_o} one cycle after the step that caused it. At W=4 the step-by-step trace checks this, and so does the exhaustive comparison against A*B. A step counter that is off by one shows up as done_o arriving a cycle early or late, and the product then has one shift too few or too many. At W=32, random operand pairs and the all-ones corner check the carry path at full width.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mul_state_e;
endpackage

// File: rtl/mul_adder.sv
module mul_adder #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         en_i,
  output logic [W-1:0] sum_o,
  output logic         co_o
);
  logic [W:0]   c;
  logic [W-1:0] bg;

  assign bg   = en_i ? b_i : '0;
  assign c[0] = 1'b0;

  for (genvar g = 0; g < W; g++) begin : g_bit
    assign sum_o[g] = a_i[g] ^ bg[g] ^ c[g];
    assign c[g+1]   = (a_i[g] & bg[g]) | (c[g] & (a_i[g] ^ bg[g]));
  end

  assign co_o = c[W];
endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import mul_pkg::*;
#(
  parameter int W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  mul_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  assign busy_o = (state_q == ST_RUN);
  assign load_o = start_i & ~busy_o;
  assign step_o = busy_o;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_o) begin
        state_q <= ST_RUN;
        cnt_q   <= '0;
      end else if (busy_o) begin
        if (cnt_q == LAST) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] mcand_i,
  input  logic [W-1:0] mplier_i,
  output logic [W-1:0] acc_o,
  output logic [W-1:0] mq_o
);
  logic [W-1:0] mdr_q, acc_q, mq_q, sum;
  logic         co;

  mul_adder #(.W(W)) u_add (
    .a_i  (acc_q),
    .b_i  (mdr_q),
    .en_i (mq_q[0]),
    .sum_o(sum),
    .co_o (co)
  );

  // carry is shifted straight into acc msb; the carry slot is then always 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mdr_q <= '0;
      acc_q <= '0;
      mq_q  <= '0;
    end else if (load_i) begin
      mdr_q <= mcand_i;
      acc_q <= '0;
      mq_q  <= mplier_i;
    end else if (step_i) begin
      acc_q <= {co, sum[W-1:1]};
      mq_q  <= {sum[0], mq_q[W-1:1]};
    end
  end

  assign acc_o = acc_q;
  assign mq_o  = mq_q;
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] mcand_i,
  input  logic [W-1:0] mplier_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] prod_hi_o,
  output logic [W-1:0] prod_lo_o
);
  logic load, step;

  mul_ctrl #(.W(W)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  mul_datapath #(.W(W)) u_dp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .step_i  (step),
    .mcand_i (mcand_i),
    .mplier_i(mplier_i),
    .acc_o   (prod_hi_o),
    .mq_o    (prod_lo_o)
  );
endmodule

// File: rtl/mul_chk.sv
module mul_chk #(
  parameter int W = 4
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic [W-1:0] mcand_i,
  input logic [W-1:0] mplier_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] prod_hi_o,
  input logic [W-1:0] prod_lo_o
);
  localparam int CW = $clog2(W + 2);

  logic          acc_ok;
  logic [W-1:0]  cap_a, cap_b;
  logic [CW-1:0] bcnt;
  logic [2*W-1:0] exp_p;

  assign acc_ok = start_i & ~busy_o;
  assign exp_p  = {{W{1'b0}}, cap_a} * {{W{1'b0}}, cap_b};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_a <= '0;
      cap_b <= '0;
      bcnt  <= '0;
    end else if (acc_ok) begin
      cap_a <= mcand_i;
      cap_b <= mplier_i;
      bcnt  <= '0;
    end else if (busy_o) begin
      bcnt <= bcnt + 1'b1;
    end
  end

  always_comb begin
    if (!rst_ni) a_r1_reset_idle: assert (!busy_o && !done_o && prod_hi_o == '0 && prod_lo_o == '0);
  end

  a_r2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_ok |=> busy_o && prod_hi_o == '0 && prod_lo_o == $past(mplier_i));

  a_r4_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r4_fall_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  a_r4_step_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (bcnt == CW'(W)) && !busy_o);

  a_r5_product: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> {prod_hi_o, prod_lo_o} == exp_p);

  a_r6_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && bcnt < CW'(W - 1)) |=> busy_o);

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(prod_hi_o) && $stable(prod_lo_o));
endmodule

bind shift_add_mul mul_chk #(.W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .mcand_i  (mcand_i),
  .mplier_i (mplier_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .prod_hi_o(prod_hi_o),
  .prod_lo_o(prod_lo_o)
);

// File: tb/shift_add_mul_bench.sv
`timescale 1ns/1ps
module shift_add_mul_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int total = 0;
  int bad = 0;

  // W = 4 instance
  logic       s4 = 1'b0;
  logic [3:0] a4 = '0, b4 = '0;
  logic       busy4, done4;
  logic [3:0] hi4, lo4;

  shift_add_mul #(.W(4)) u_shift_add_mul (
    .clk_i(clk), .rst_ni(rst_n), .start_i(s4), .mcand_i(a4), .mplier_i(b4),
    .busy_o(busy4), .done_o(done4), .prod_hi_o(hi4), .prod_lo_o(lo4)
  );

  // W = 32 instance
  logic        s32 = 1'b0;
  logic [31:0] a32 = '0, b32 = '0;
  logic        busy32, done32;
  logic [31:0] hi32, lo32;

  shift_add_mul #(.W(32)) u_shift_add_mul_w32 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(s32), .mcand_i(a32), .mplier_i(b32),
    .busy_o(busy32), .done_o(done32), .prod_hi_o(hi32), .prod_lo_o(lo32)
  );

  function automatic logic [63:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
    return {32'b0, a} * {32'b0, b};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // full W=4 operation; trace=1 checks the R3 example sequence
  task automatic mul4(input logic [3:0] a, input logic [3:0] b, input bit trace);
    logic [7:0] seq [4];
    seq[0] = 8'h7A; seq[1] = 8'h3D; seq[2] = 8'h96; seq[3] = 8'h4B;
    @(negedge clk); s4 = 1'b1; a4 = a; b4 = b;
    @(negedge clk); s4 = 1'b0;
    chk(busy4 && hi4 == 4'h0 && lo4 == b, "R2", {55'b0, busy4, hi4, lo4}, {55'b0, 1'b1, 4'h0, b});
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      if (trace) chk({hi4, lo4} == seq[k-1], "R3", {56'b0, hi4, lo4}, {56'b0, seq[k-1]});
      if (k < 4) begin
        if (trace) chk(busy4 && !done4, "R4", {62'b0, busy4, done4}, 64'd2);
      end else begin
        chk(!busy4 && done4, "R4", {62'b0, busy4, done4}, 64'd1);
        chk({hi4, lo4} == 8'(ref_mul({28'b0, a}, {28'b0, b})), "R5",
            {56'b0, hi4, lo4}, ref_mul({28'b0, a}, {28'b0, b}));
      end
    end
    @(negedge clk);
    if (trace) chk(!done4, "R4", {63'b0, done4}, 64'd0);
  endtask

  task automatic mul32(input logic [31:0] a, input logic [31:0] b, input string req);
    @(negedge clk); s32 = 1'b1; a32 = a; b32 = b;
    @(negedge clk); s32 = 1'b0;
    for (int k = 1; k <= 32; k++) @(negedge clk);
    chk(done32 && !busy32 && {hi32, lo32} == ref_mul(a, b), req, {hi32, lo32}, ref_mul(a, b));
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] held;
    void'($urandom(32'd1357));
    #23;
    // R1 reset state (checked while reset is asserted and just after release)
    chk(!busy4 && !done4 && hi4 == 0 && lo4 == 0, "R1", {54'b0, busy4, done4, hi4, lo4}, 64'd0);
    chk(!busy32 && !done32 && hi32 == 0 && lo32 == 0, "R1", {hi32, lo32}, 64'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(!busy4 && !done4 && hi4 == 0 && lo4 == 0, "R1", {54'b0, busy4, done4, hi4, lo4}, 64'd0);

    // R3 / R4 worked example
    mul4(4'hF, 4'h5, 1'b1);

    // R8 carry corner
    mul4(4'hF, 4'hF, 1'b0);
    chk(busy4 == 1'b0 && {hi4, lo4} == 8'hE1, "R8", {56'b0, hi4, lo4}, 64'hE1);

    // R7 hold: operands wiggle without start
    held = {hi4, lo4};
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); a4 = 4'($urandom); b4 = 4'($urandom);
    end
    @(negedge clk);
    chk({hi4, lo4} == held && !busy4 && !done4, "R7", {56'b0, hi4, lo4}, {56'b0, held});

    // R6 start ignored while busy
    @(negedge clk); s4 = 1'b1; a4 = 4'd3; b4 = 4'd5;
    @(negedge clk); s4 = 1'b0;
    @(negedge clk); s4 = 1'b1; a4 = 4'd15; b4 = 4'd15;
    @(negedge clk); s4 = 1'b0; a4 = 4'd9; b4 = 4'd9;
    @(negedge clk);
    chk(busy4 && !done4, "R6", {62'b0, busy4, done4}, 64'd2);
    @(negedge clk);
    chk(done4 && !busy4 && {hi4, lo4} == 8'd15, "R6", {56'b0, hi4, lo4}, 64'd15);

    // R5 exhaustive at W=4
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        mul4(4'(i), 4'(j), 1'b0);

    // W=32 directed corners and random pairs
    mul32(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R8");
    mul32(32'h0, 32'hFFFF_FFFF, "R5");
    mul32(32'h1, 32'h8000_0001, "R5");
    mul32(32'h8000_0000, 32'h8000_0000, "R8");
    for (int k = 0; k < 200; k++) mul32($urandom, $urandom, "R5");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule